// File: doc/BRIEF.md
# Three-channel tone and noise mixer

This block forms the digital amplitude code of each of the three voices of a programmable sound generator. Each voice has a 12-bit tone divider that makes a square wave. One pseudo-random noise source is shared by all three voices. A per-voice mixer gates the voice with its tone and its noise. A level selector then picks, for each voice, either a fixed 4-bit level or a 5-bit envelope value that is supplied from outside. The register contents arrive as parallel inputs that are already decoded. The block therefore has no bus logic of its own.

Everything runs on one clock. The master rate is an enable pulse derived inside the block. It fires on every input clock when the rate-select pin is high, and on every second clock when the pin is low. A fixed divide-by-eight of the master pulses steps the tone and noise dividers. The three amplitude codes feed a DAC that lies outside this block. The raw tone bits and the noise bit are also brought out for debugging.

Top module: `psg_tone_mixer`

## Requirements
- R1: With `full_rate_i` high a master pulse occurs on every clock. With it low a master pulse occurs on every second clock, and the first one comes on the second clock after reset. Every eighth master pulse is a divider step.
- R2: Each tone bit starts at 0 after reset and toggles on every Nth divider step, where N is the effective period. The full square-wave period is therefore 16·N master pulses. The divider counter restarts at each toggle. If the period is lowered to or below the current count, the bit toggles on the next step.
- R3: A tone period of 0 behaves exactly like a period of 1.
- R4: Noise comes from a 17-bit shift register seeded to 1 at reset. On each advance it shifts right, and bit 0 XOR bit 3 enters at bit 16. The noise bit is register bit 0. It advances once every 2·M divider steps, which is 16·M master pulses, where M is the 5-bit noise period. A value of 0 behaves as 1.
- R5: Mixer control `mix_ctrl_i` is active-low. Bits 0, 1 and 2 disable tone on voices A, B and C. Bits 3, 4 and 5 disable noise on voices A, B and C.
- R6: A voice's gate is (tone OR tone-disable) AND (noise OR noise-disable). When the gate is 0 the amplitude code is 0.
- R7: Level input bit 4 is the mode bit. When it is 0 and the gate is open, the amplitude is {level[3:0], 1}. When it is 1 and the gate is open, the amplitude is `env_lvl_i`.
- R8: After reset the tone bits are 000, the noise bit is 1, and all counters are cleared.
- R9: A voice with both sources disabled has a permanently open gate. Its amplitude then follows its level selection with no modulation.
- R10: `tone_o` bit k carries voice k's square wave (0=A, 1=B, 2=C). `noise_o` carries the shared noise bit. Both come straight from registers and change only after a divider step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| full_rate_i | input | 1 | 1: master rate = clock; 0: clock / 2 |
| tone_per_a_i | input | 12 | Tone period, voice A |
| tone_per_b_i | input | 12 | Tone period, voice B |
| tone_per_c_i | input | 12 | Tone period, voice C |
| noise_per_i | input | 5 | Noise period |
| mix_ctrl_i | input | 6 | Active-low tone (2:0) and noise (5:3) enables |
| lvl_a_i | input | 5 | Mode bit 4, fixed level 3:0, voice A |
| lvl_b_i | input | 5 | Mode bit 4, fixed level 3:0, voice B |
| lvl_c_i | input | 5 | Mode bit 4, fixed level 3:0, voice C |
| env_lvl_i | input | 5 | Envelope value shared by all voices |
| amp_a_o | output | 5 | Amplitude code, voice A |
| amp_b_o | output | 5 | Amplitude code, voice B |
| amp_c_o | output | 5 | Amplitude code, voice C |
| tone_o | output | 3 | Tone bits, C B A |
| noise_o | output | 1 | Noise bit |

## Verification
The bench aims at several risky points:
- The half-rate phase right after reset. A prescaler that ticks on the first clock would shift every edge by one cycle.
- Periods of 0 and 1. A design that does not map 0 to 1 would stall the voice or run 4096 steps long.
- A period lowered below a running count. A design using an equality compare would wrap the counter instead of toggling.

It also walks through each mixer bit on its own, so a swapped tone and noise field, or a swapped voice order, shows up as a wrong code on one voice. The fixed-level LSB is checked as well. The exact noise sequence exposes a wrong tap, a wrong seed or a wrong step rate within a few advances.

// File: rtl/psg_mix_pkg.sv
package psg_mix_pkg;

    localparam int unsigned PSG_TONE_W  = 12;
    localparam int unsigned PSG_NOISE_W = 5;
    localparam int unsigned PSG_LVL_W   = 4;
    localparam int unsigned PSG_LFSR_W  = 17;
    localparam int unsigned PSG_LFSR_TAP = 3;
    localparam int unsigned PSG_PRE_DIV = 8;
    localparam int unsigned PSG_VOICES  = 3;

    typedef enum logic {
        RATE_HALF = 1'b0,
        RATE_FULL = 1'b1
    } psg_rate_e;

endpackage

// File: rtl/psg_clk_prescale.sv
module psg_clk_prescale #(
    parameter int unsigned DIV = psg_mix_pkg::PSG_PRE_DIV
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic full_rate_i,
    output logic step_o
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    typedef struct packed {
        logic          half;
        logic [CW-1:0] div;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic master;

    always_comb begin
        st_d      = st_q;
        master    = (full_rate_i == psg_mix_pkg::RATE_FULL) | st_q.half;
        st_d.half = ~st_q.half;
        step_o    = 1'b0;
        if (master) begin
            if (st_q.div == LAST) begin
                st_d.div = '0;
                step_o   = 1'b1;
            end else begin
                st_d.div = st_q.div + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/psg_tone_div.sv
module psg_tone_div #(
    parameter int unsigned W = psg_mix_pkg::PSG_TONE_W
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         step_i,
    input  logic [W-1:0] period_i,
    output logic         wave_o
);
    typedef struct packed {
        logic         wave;
        logic [W-1:0] cnt;
    } tone_state_t;

    tone_state_t st_d, st_q;
    logic [W:0] eff_per;
    logic [W:0] cnt_inc;

    always_comb begin
        st_d    = st_q;
        eff_per = (period_i == '0) ? (W+1)'(1) : {1'b0, period_i};
        cnt_inc = {1'b0, st_q.cnt} + 1'b1;
        if (step_i) begin
            if (cnt_inc >= eff_per) begin
                st_d.cnt  = '0;
                st_d.wave = ~st_q.wave;
            end else begin
                st_d.cnt = cnt_inc[W-1:0];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wave_o = st_q.wave;
endmodule

// File: rtl/psg_noise_gen.sv
module psg_noise_gen #(
    parameter int unsigned PW  = psg_mix_pkg::PSG_NOISE_W,
    parameter int unsigned LW  = psg_mix_pkg::PSG_LFSR_W,
    parameter int unsigned TAP = psg_mix_pkg::PSG_LFSR_TAP
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          step_i,
    input  logic [PW-1:0] period_i,
    output logic          bit_o
);
    localparam int unsigned CW = PW + 2;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [LW-1:0] lfsr;
    } noise_state_t;

    noise_state_t st_d, st_q;
    logic [CW-1:0] limit;
    logic [CW-1:0] cnt_inc;

    always_comb begin
        st_d    = st_q;
        limit   = (period_i == '0) ? CW'(2) : {1'b0, period_i, 1'b0};
        cnt_inc = st_q.cnt + 1'b1;
        if (step_i) begin
            if (cnt_inc >= limit) begin
                st_d.cnt  = '0;
                st_d.lfsr = {st_q.lfsr[0] ^ st_q.lfsr[TAP], st_q.lfsr[LW-1:1]};
            end else begin
                st_d.cnt = cnt_inc;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.cnt  <= '0;
            st_q.lfsr <= LW'(1);
        end else begin
            st_q <= st_d;
        end
    end

    assign bit_o = st_q.lfsr[0];
endmodule

// File: rtl/psg_chan_mix.sv
module psg_chan_mix #(
    parameter int unsigned LVL_W = psg_mix_pkg::PSG_LVL_W,
    localparam int unsigned AMP_W = LVL_W + 1
) (
    input  logic             tone_i,
    input  logic             noise_i,
    input  logic             tone_dis_i,
    input  logic             noise_dis_i,
    input  logic [LVL_W:0]   level_i,
    input  logic [AMP_W-1:0] env_i,
    output logic [AMP_W-1:0] amp_o
);
    logic gate;
    logic [AMP_W-1:0] chosen;

    always_comb begin
        gate   = (tone_i | tone_dis_i) & (noise_i | noise_dis_i);
        chosen = level_i[LVL_W] ? env_i : {level_i[LVL_W-1:0], 1'b1};
        amp_o  = gate ? chosen : '0;
    end
endmodule

// File: rtl/psg_tone_mixer.sv
module psg_tone_mixer #(
    parameter int unsigned TONE_W  = psg_mix_pkg::PSG_TONE_W,
    parameter int unsigned NOISE_W = psg_mix_pkg::PSG_NOISE_W,
    parameter int unsigned LVL_W   = psg_mix_pkg::PSG_LVL_W,
    parameter int unsigned LFSR_W  = psg_mix_pkg::PSG_LFSR_W,
    parameter int unsigned PRE_DIV = psg_mix_pkg::PSG_PRE_DIV
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               full_rate_i,
    input  logic [TONE_W-1:0]  tone_per_a_i,
    input  logic [TONE_W-1:0]  tone_per_b_i,
    input  logic [TONE_W-1:0]  tone_per_c_i,
    input  logic [NOISE_W-1:0] noise_per_i,
    input  logic [5:0]         mix_ctrl_i,
    input  logic [LVL_W:0]     lvl_a_i,
    input  logic [LVL_W:0]     lvl_b_i,
    input  logic [LVL_W:0]     lvl_c_i,
    input  logic [LVL_W:0]     env_lvl_i,
    output logic [LVL_W:0]     amp_a_o,
    output logic [LVL_W:0]     amp_b_o,
    output logic [LVL_W:0]     amp_c_o,
    output logic [2:0]         tone_o,
    output logic               noise_o
);
    localparam int unsigned NV    = psg_mix_pkg::PSG_VOICES;
    localparam int unsigned AMP_W = LVL_W + 1;

    logic                    step;
    logic                    noise_bit;
    logic [NV-1:0]           tone_bits;
    logic [TONE_W-1:0]       per_arr [NV];
    logic [LVL_W:0]          lvl_arr [NV];
    logic [AMP_W-1:0]        amp_arr [NV];

    assign per_arr[0] = tone_per_a_i;
    assign per_arr[1] = tone_per_b_i;
    assign per_arr[2] = tone_per_c_i;
    assign lvl_arr[0] = lvl_a_i;
    assign lvl_arr[1] = lvl_b_i;
    assign lvl_arr[2] = lvl_c_i;

    psg_clk_prescale #(.DIV(PRE_DIV)) u_pre (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .full_rate_i (full_rate_i),
        .step_o      (step)
    );

    psg_noise_gen #(
        .PW  (NOISE_W),
        .LW  (LFSR_W),
        .TAP (psg_mix_pkg::PSG_LFSR_TAP)
    ) u_noise (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .step_i   (step),
        .period_i (noise_per_i),
        .bit_o    (noise_bit)
    );

    for (genvar v = 0; v < NV; v++) begin : g_voice
        psg_tone_div #(.W(TONE_W)) u_tone (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .step_i   (step),
            .period_i (per_arr[v]),
            .wave_o   (tone_bits[v])
        );

        psg_chan_mix #(.LVL_W(LVL_W)) u_mix (
            .tone_i      (tone_bits[v]),
            .noise_i     (noise_bit),
            .tone_dis_i  (mix_ctrl_i[v]),
            .noise_dis_i (mix_ctrl_i[v+NV]),
            .level_i     (lvl_arr[v]),
            .env_i       (env_lvl_i),
            .amp_o       (amp_arr[v])
        );
    end

    assign amp_a_o = amp_arr[0];
    assign amp_b_o = amp_arr[1];
    assign amp_c_o = amp_arr[2];
    assign tone_o  = tone_bits;
    assign noise_o = noise_bit;
endmodule

// File: rtl/psg_tone_mixer_chk.sv
module psg_tone_mixer_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       tone_dis_a,
    input logic       noise_dis_a,
    input logic [4:0] lvl_a_i,
    input logic [4:0] amp_a_o,
    input logic       tone_a,
    input logic       noise_o
);
    AST_GATED_OFF_IS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tone_dis_a && !tone_a) |-> (amp_a_o == 5'd0)); // R6

    AST_FIXED_LEVEL_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!lvl_a_i[4] && amp_a_o != 5'd0) |-> (amp_a_o == {lvl_a_i[3:0], 1'b1})); // R7

    AST_BOTH_OFF_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tone_dis_a && noise_dis_a && !lvl_a_i[4]) |-> (amp_a_o == {lvl_a_i[3:0], 1'b1})); // R9

    AST_TONE_MIN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(tone_a) |=> $stable(tone_a)); // R2

    AST_NOISE_MIN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(noise_o) |=> $stable(noise_o)); // R4
endmodule

bind psg_tone_mixer psg_tone_mixer_chk chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tone_dis_a  (mix_ctrl_i[0]),
    .noise_dis_a (mix_ctrl_i[3]),
    .lvl_a_i     (lvl_a_i),
    .amp_a_o     (amp_a_o),
    .tone_a      (tone_o[0]),
    .noise_o     (noise_o)
);

// File: tb/psg_tone_mixer_tb_top.sv
module psg_tone_mixer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        full_rate = 1'b1;
    logic [11:0] tp [3];
    logic [4:0]  np = 5'd0;
    logic [5:0]  mix = 6'd0;
    logic [4:0]  lvl [3];
    logic [4:0]  env = 5'd0;
    logic [4:0]  amp_a, amp_b, amp_c;
    logic [2:0]  tone;
    logic        noise;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;
    string req  = "R8";

    // reference state
    int m_half, m_div, m_ncnt, m_lfsr;
    int m_tcnt [3];
    int m_tone [3];

    always #4 clk = ~clk;

    psg_tone_mixer dut_i (
        .clk_i(clk), .rst_ni(rst_n), .full_rate_i(full_rate),
        .tone_per_a_i(tp[0]), .tone_per_b_i(tp[1]), .tone_per_c_i(tp[2]),
        .noise_per_i(np), .mix_ctrl_i(mix),
        .lvl_a_i(lvl[0]), .lvl_b_i(lvl[1]), .lvl_c_i(lvl[2]),
        .env_lvl_i(env),
        .amp_a_o(amp_a), .amp_b_o(amp_b), .amp_c_o(amp_c),
        .tone_o(tone), .noise_o(noise)
    );

    task automatic chk(string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int exp_amp(int v);
        int gate, tdis, ndis;
        tdis = (mix >> v) & 1;
        ndis = (mix >> (v + 3)) & 1;
        gate = (m_tone[v] | tdis) & ((m_lfsr & 1) | ndis);
        if (gate == 0) return 0;
        if (lvl[v][4]) return int'(env);
        return int'(lvl[v][3:0]) * 2 + 1;
    endfunction

    task automatic compare_all();
        chk("tone A (R10)", int'(tone[0]), m_tone[0]);
        chk("tone B (R10)", int'(tone[1]), m_tone[1]);
        chk("tone C (R10)", int'(tone[2]), m_tone[2]);
        chk("noise (R4)", int'(noise), m_lfsr & 1);
        chk("amp A (R6 R7)", int'(amp_a), exp_amp(0));
        chk("amp B (R6 R7)", int'(amp_b), exp_amp(1));
        chk("amp C (R6 R7)", int'(amp_c), exp_amp(2));
    endtask

    // advance reference across the coming rising edge using current inputs
    task automatic model_edge();
        int master, step, p, lim;
        master = full_rate | m_half;
        m_half ^= 1;
        step = 0;
        if (master != 0) begin
            if (m_div == 7) begin m_div = 0; step = 1; end
            else m_div++;
        end
        if (step != 0) begin
            for (int v = 0; v < 3; v++) begin
                p = (tp[v] == 0) ? 1 : int'(tp[v]);
                if (m_tcnt[v] + 1 >= p) begin m_tcnt[v] = 0; m_tone[v] ^= 1; end
                else m_tcnt[v]++;
            end
            lim = 2 * ((np == 0) ? 1 : int'(np));
            if (m_ncnt + 1 >= lim) begin
                m_ncnt = 0;
                m_lfsr = (m_lfsr >> 1) | (((m_lfsr ^ (m_lfsr >> 3)) & 1) << 16);
            end else m_ncnt++;
        end
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) begin
            model_edge();
            @(negedge clk);
            compare_all();
        end
    endtask

    initial begin
        for (int v = 0; v < 3; v++) begin
            tp[v] = 12'd0; lvl[v] = 5'd0; m_tcnt[v] = 0; m_tone[v] = 0;
        end
        m_half = 0; m_div = 0; m_ncnt = 0; m_lfsr = 1;
        repeat (3) @(negedge clk);
        req = "R8";
        lvl[0] = 5'd3; lvl[1] = 5'd7; lvl[2] = 5'd15;
        #1;
        chk("reset tone_o (R8)", int'(tone), 0);
        chk("reset noise_o (R8)", int'(noise), 1);
        chk("reset amp A gated (R8)", int'(amp_a), 0);
        rst_n = 1'b1;

        // tone only, full rate, periods 3,1,0
        req = "R2"; mix = 6'b111_000; tp[0] = 12'd3; tp[1] = 12'd1; tp[2] = 12'd0;
        lvl[0] = 5'd5; lvl[1] = 5'd9; lvl[2] = 5'd15;
        run(200);
        req = "R3"; tp[0] = 12'd0; run(100);

        // half rate
        req = "R1"; full_rate = 1'b0; tp[0] = 12'd2; tp[1] = 12'd5; tp[2] = 12'd1;
        run(400);
        full_rate = 1'b1;

        // period lowered below running count
        req = "R2"; tp[1] = 12'd20; run(120); tp[1] = 12'd2; run(60);

        // noise only
        req = "R4"; mix = 6'b000_111; np = 5'd2; run(500);
        np = 5'd0; run(300);
        np = 5'd31; run(1200);

        // both enabled, envelope mode
        req = "R7"; mix = 6'b000_000; np = 5'd1; tp[0] = 12'd1; tp[1] = 12'd3; tp[2] = 12'd7;
        lvl[0] = 5'h10; lvl[1] = 5'h1A; lvl[2] = 5'h06;
        for (int k = 0; k < 32; k++) begin env = 5'(k); run(12); end

        // both disabled
        req = "R9"; mix = 6'b111_111; lvl[0] = 5'h00; lvl[1] = 5'h0C; lvl[2] = 5'h1F; env = 5'd21;
        run(150);

        // per-voice field placement
        req = "R5"; mix = 6'b101_110; lvl[0] = 5'h04; lvl[1] = 5'h0B; lvl[2] = 5'h0E;
        run(300);
        mix = 6'b011_101; run(300);
        mix = 6'b110_011; run(300);

        req = "R6"; mix = 6'b000_000; lvl[0] = 5'h0F; lvl[1] = 5'h0F; lvl[2] = 5'h0F;
        run(400);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule